// File: doc/BRIEF.md
# PWM Input Period and High-Time Meter

This block measures an external pulse-width-modulated signal. It counts the period and the high time in ticks of an internal counter. The caller picks one of two input pins, sets a clock divider for the counter, a counter modulus, an edge-divide ratio and a timeout, and then pulses `start`. The selected pin passes through a two-flop synchronizer. Rising and falling edges then drive two capture registers that sample one shared, free-running counter.

A pair of capture values is read a fixed `READ_LAG` clocks after each rising capture. This models the delay of a reader that collects both registers together. The first read supplies the reference time. The second read supplies the period end and the falling-edge time. The arithmetic corrects for counter wraparound. It also corrects for a falling capture that landed between the second rising capture and its read, and for edge-divided capture that began during the high phase.

The result leaves on a valid/ready stream. `res_valid` acts as the done flag. The period and high time stay frozen until `res_ready` is seen high with `res_valid`. The block takes no new `start` until that handshake completes. If no result arrives within the timeout, a separate timeout flag is raised instead.

Top module: `pwmcap_top`

## Requirements
- R1: After reset, `res_valid` and `timed_out` are 0.
- R2: `start` is accepted only while idle. A `start` while a measurement runs or a result is pending has no effect: a pending result stays valid with unchanged values.
- R3: During a measurement the counter advances once every `tick_div`+1 clocks. It counts 0 up to `cnt_mod`-1 and then returns to 0. An edge separation of S clocks, with S a multiple of `tick_div`+1, is reported as S/(`tick_div`+1) ticks.
- R4: `pin_sel`=0 measures `pin_a` and `pin_sel`=1 measures `pin_b`. The other pin has no effect on the result.
- R5: The raw period is t2-t0, where t0 and t2 are the first and second rising-capture values. If t2 < t0, the raw period is `cnt_mod`-t0+t2.
- R6: The raw high time is t1-t0, where t1 is the falling capture register as read with the second pair. If t1 < t0, the raw high time is `cnt_mod`-t0+t1.
- R7: The pair is read `READ_LAG` clocks after a rising capture. A falling capture in the same cycle as the read is not included. If the raw high time exceeds the raw period, the raw period is subtracted from it. The result is therefore correct for high times both shorter than and equal to `READ_LAG` clocks.
- R8: `edge_div` = k (0..3) captures on every 2^k-th edge of each polarity, counted from `start`. The reported period is the raw period shifted right by k.
- R9: When k > 0 and the high time is at least the reported period, the reported high time is the reported period minus (raw period - high time). This makes a start during the high phase yield the true high time.
- R10: `res_valid` holds, with `res_period` and `res_high` stable, until a cycle with `res_ready` high. After that cycle it is 0.
- R11: If no result is produced within `tmo_limit` clocks of the accepted `start`, `timed_out` becomes 1 and no result is issued. `timed_out` is cleared by the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_a | input | 1 | First candidate PWM input (asynchronous) |
| pin_b | input | 1 | Second candidate PWM input (asynchronous) |
| pin_sel | input | 1 | 0 selects pin_a, 1 selects pin_b |
| tick_div | input | PSC_W | Counter advances every tick_div+1 clocks |
| cnt_mod | input | CNT_W | Counter modulus (at least 2) |
| edge_div | input | 2 | Capture every 2^edge_div edges |
| tmo_limit | input | TMO_W | Timeout in clocks from start |
| start | input | 1 | One-cycle request to begin a measurement |
| res_valid | output | 1 | Result available (done flag) |
| res_ready | input | 1 | Consumer accepts the result |
| res_period | output | CNT_W | Period in counter ticks |
| res_high | output | CNT_W | High time in counter ticks |
| timed_out | output | 1 | Measurement abandoned by timeout |

## Verification
The falling-edge capture and the delayed pair read can land in the same clock cycle. This happens when the high time equals `READ_LAG`. The bench provokes it with a high time of exactly `READ_LAG` clocks and a second one that is one clock shorter. The shorter case forces the overwritten-capture path. Both are judged by the reported high time matching the driven one, which shows that the same-cycle read takes the older capture and that the race subtraction restores the value.

// File: rtl/pwmcap_pkg.sv
package pwmcap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEAS = 2'd1,
    ST_DONE = 2'd2
  } cap_state_e;

  localparam int EDIV_W  = 2;
  localparam int EPH_W   = 3;
  localparam int NUM_EDG = 2;
endpackage

// File: rtl/pwmcap_insel.sv
module pwmcap_insel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_a,
  input  logic pin_b,
  input  logic pin_sel,
  output logic rise,
  output logic fall
);
  logic                 raw_pin;
  logic [SYNC_STAGES:0] shreg;

  assign raw_pin = pin_sel ? pin_b : pin_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[SYNC_STAGES-1:0], raw_pin};
  end

  // shreg[SYNC_STAGES-1] is the synchronized level, the top bit its history
  assign rise =  shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];
  assign fall = ~shreg[SYNC_STAGES-1] &  shreg[SYNC_STAGES];
endmodule

// File: rtl/pwmcap_timebase.sv
module pwmcap_timebase #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] tick_div,
  input  logic [CNT_W-1:0] cnt_mod,
  output logic [CNT_W-1:0] cnt
);
  logic [PSC_W-1:0] pre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      cnt <= '0;
    end else if (!run) begin
      pre <= '0;
      cnt <= '0;
    end else if (pre == tick_div) begin
      pre <= '0;
      cnt <= (cnt == cnt_mod - 1'b1) ? '0 : cnt + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end
endmodule

// File: rtl/pwmcap_evdiv.sv
module pwmcap_evdiv
  import pwmcap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ev,
  input  logic [EDIV_W-1:0] ratio,
  output logic              hit
);
  logic [EPH_W-1:0] ph;
  logic [EPH_W:0]   span;
  logic [EPH_W-1:0] mask;

  assign span = ({{EPH_W{1'b0}}, 1'b1} << ratio) - 1'b1;
  assign mask = span[EPH_W-1:0];
  assign hit  = ev && ((ph & mask) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ph <= '0;
    else if (clr)   ph <= '0;
    else if (ev)    ph <= (ph + 1'b1) & mask;
  end
endmodule

// File: rtl/pwmcap_calc.sv
module pwmcap_calc
  import pwmcap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0]  t_ref,
  input  logic [CNT_W-1:0]  t_fall,
  input  logic [CNT_W-1:0]  t_end,
  input  logic [CNT_W-1:0]  cnt_mod,
  input  logic [EDIV_W-1:0] ratio,
  output logic [CNT_W-1:0]  period,
  output logic [CNT_W-1:0]  high
);
  localparam int W = CNT_W + 1;

  function automatic logic [W-1:0] span(input logic [CNT_W-1:0] a,
                                        input logic [CNT_W-1:0] b,
                                        input logic [CNT_W-1:0] m);
    if (a <= b) span = {1'b0, b} - {1'b0, a};
    else        span = {1'b0, m} - {1'b0, a} + {1'b0, b};
  endfunction

  logic [W-1:0] raw_p, raw_h, race_h, one_p, fix_h;

  always_comb begin
    raw_p  = span(t_ref, t_end, cnt_mod);
    raw_h  = span(t_ref, t_fall, cnt_mod);
    race_h = (raw_h > raw_p) ? raw_h - raw_p : raw_h;
    one_p  = raw_p >> ratio;
    if (ratio != '0 && race_h >= one_p) fix_h = one_p - (raw_p - race_h);
    else                                fix_h = race_h;
    period = one_p[CNT_W-1:0];
    high   = fix_h[CNT_W-1:0];
  end
endmodule

// File: rtl/pwmcap_top.sv
module pwmcap_top
  import pwmcap_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PSC_W    = 8,
  parameter int TMO_W    = 20,
  parameter int READ_LAG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_a,
  input  logic              pin_b,
  input  logic              pin_sel,
  input  logic [PSC_W-1:0]  tick_div,
  input  logic [CNT_W-1:0]  cnt_mod,
  input  logic [1:0]        edge_div,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic              start,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [CNT_W-1:0]  res_period,
  output logic [CNT_W-1:0]  res_high,
  output logic              timed_out
);
  localparam int LAG_W = $clog2(READ_LAG + 1);

  cap_state_e          state;
  logic                meas;
  logic                rise, fall;
  logic [NUM_EDG-1:0]  evs, hits;
  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    cap_r, cap_f, t0;
  logic                lag_on, second;
  logic [LAG_W-1:0]    lag_cnt;
  logic [TMO_W-1:0]    tmo_cnt;
  logic [CNT_W-1:0]    calc_p, calc_h, period_q, high_q;
  logic                read_now, finish;

  assign meas = (state == ST_MEAS);

  pwmcap_insel #(.SYNC_STAGES(2)) i_insel (
    .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b),
    .pin_sel(pin_sel), .rise(rise), .fall(fall)
  );

  pwmcap_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) i_tb (
    .clk(clk), .rst_n(rst_n), .run(meas), .tick_div(tick_div),
    .cnt_mod(cnt_mod), .cnt(cnt)
  );

  // index 0: rising-edge capture unit, index 1: falling-edge capture unit
  assign evs = {fall, rise};
  for (genvar g = 0; g < NUM_EDG; g++) begin : g_div
    pwmcap_evdiv i_div (
      .clk(clk), .rst_n(rst_n), .clr(!meas), .ev(evs[g]),
      .ratio(edge_div), .hit(hits[g])
    );
  end

  pwmcap_calc #(.CNT_W(CNT_W)) i_calc (
    .t_ref(t0), .t_fall(cap_f), .t_end(cap_r), .cnt_mod(cnt_mod),
    .ratio(edge_div), .period(calc_p), .high(calc_h)
  );

  assign read_now = lag_on && (lag_cnt == LAG_W'(READ_LAG - 1));
  assign finish   = read_now && second;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cap_r     <= '0;
      cap_f     <= '0;
      t0        <= '0;
      lag_on    <= 1'b0;
      lag_cnt   <= '0;
      second    <= 1'b0;
      tmo_cnt   <= '0;
      period_q  <= '0;
      high_q    <= '0;
      timed_out <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_MEAS;
            cap_r     <= '0;
            cap_f     <= '0;
            lag_on    <= 1'b0;
            lag_cnt   <= '0;
            second    <= 1'b0;
            tmo_cnt   <= '0;
            timed_out <= 1'b0;
          end
        end
        ST_MEAS: begin
          tmo_cnt <= tmo_cnt + 1'b1;
          if (lag_on) lag_cnt <= lag_cnt + 1'b1;
          // pair read samples the capture registers before this edge
          if (read_now) begin
            lag_on <= 1'b0;
            if (!second) begin
              t0     <= cap_r;
              second <= 1'b1;
            end else begin
              period_q <= calc_p;
              high_q   <= calc_h;
              state    <= ST_DONE;
            end
          end
          if (hits[1]) cap_f <= cnt;
          if (hits[0]) begin
            cap_r   <= cnt;
            lag_on  <= 1'b1;
            lag_cnt <= '0;
          end
          // a completing read wins over an expiring timeout
          if (!finish && tmo_cnt == tmo_limit - 1'b1) begin
            timed_out <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        ST_DONE: begin
          if (res_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign res_valid  = (state == ST_DONE);
  assign res_period = period_q;
  assign res_high   = high_q;
endmodule

// File: rtl/pwmcap_chk.sv
module pwmcap_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             res_valid,
  input logic             res_ready,
  input logic [CNT_W-1:0] res_period,
  input logic [CNT_W-1:0] res_high,
  input logic             timed_out,
  input logic             busy,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cnt_mod
);
  // R10: a pending result stays valid and frozen until taken
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_period) && $stable(res_high)));

  // R11: timeout and a valid result never coexist
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && timed_out));

  // R11: timeout only ends a running measurement
  a_r11_from_meas: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timed_out) |-> $past(busy));

  // R2: a measurement begins only on a start request
  a_r2_begin_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start) && !$past(res_valid));

  // R3: counter stays below its modulus
  a_r3_range: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_mod != '0) |-> (cnt < cnt_mod));

  // R3: counter moves by one step or wraps to zero
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1 || cnt == '0));
endmodule

bind pwmcap_top pwmcap_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .res_valid(res_valid),
  .res_ready(res_ready), .res_period(res_period), .res_high(res_high),
  .timed_out(timed_out), .busy(meas), .cnt(cnt), .cnt_mod(cnt_mod)
);

// File: tb/test_pwmcap_top.sv
module test_pwmcap_top;
  localparam int CNT_W = 16;
  localparam int PSC_W = 8;
  localparam int TMO_W = 20;
  localparam int NV    = 11;

  // stimulus: sel, tick_div, modulus, edge_div, period, high, start offset
  localparam int V_SEL[NV] = '{0, 1, 0, 0, 0, 1, 0, 1, 0, 0, 0};
  localparam int V_PSC[NV] = '{0, 0, 3, 0, 0, 0, 0, 0, 1, 0, 0};
  localparam int V_MOD[NV] = '{1000, 1000, 1000, 50, 50, 1000, 1000, 1000, 1000, 1000, 1000};
  localparam int V_K  [NV] = '{0, 0, 0, 0, 0, 1, 1, 2, 3, 0, 0};
  localparam int V_P  [NV] = '{40, 60, 80, 40, 40, 30, 30, 24, 20, 40, 40};
  localparam int V_H  [NV] = '{10, 25, 20, 12, 30, 9, 14, 12, 12, 3, 4};
  localparam int V_OFF[NV] = '{20, 40, 40, 16, 17, 15, 6, 5, 6, 20, 20};
  // expected results in ticks
  localparam int V_EP [NV] = '{40, 60, 20, 40, 40, 30, 30, 24, 10, 40, 40};
  localparam int V_EH [NV] = '{10, 25, 5, 12, 30, 9, 14, 12, 6, 3, 4};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_a = 1'b0, pin_b = 1'b0, pin_sel = 1'b0;
  logic [PSC_W-1:0] tick_div = '0;
  logic [CNT_W-1:0] cnt_mod = 16'd1000;
  logic [1:0] edge_div = '0;
  logic [TMO_W-1:0] tmo_limit = 20'd5000;
  logic start = 1'b0, res_ready = 1'b0;
  logic res_valid, timed_out;
  logic [CNT_W-1:0] res_period, res_high;

  int nchk = 0, nfail = 0;
  int s_p = 40, s_h = 0, s_ph = 0;
  int d_ph = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  pwmcap_top #(.CNT_W(CNT_W), .PSC_W(PSC_W), .TMO_W(TMO_W)) i_pwmcap_top (
    .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b), .pin_sel(pin_sel),
    .tick_div(tick_div), .cnt_mod(cnt_mod), .edge_div(edge_div),
    .tmo_limit(tmo_limit), .start(start), .res_valid(res_valid),
    .res_ready(res_ready), .res_period(res_period), .res_high(res_high),
    .timed_out(timed_out)
  );

  function automatic string vtag(int i);
    case (i)
      1: return "R4";
      2: return "R3";
      3: return "R5";
      4: return "R6 wrap";
      5, 8: return "R8";
      6, 7: return "R9";
      9, 10: return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: drive both pins at the falling edge
  task automatic step();
    logic sv, dv;
    @(negedge clk);
    sv = (s_ph >= 0) && (s_ph < s_h);
    if (s_ph < 0) s_ph++;
    else s_ph = (s_ph + 1 >= s_p) ? 0 : s_ph + 1;
    dv = (d_ph < 11);
    d_ph = (d_ph + 1 >= 37) ? 0 : d_ph + 1;
    if (pin_sel) begin pin_b = sv; pin_a = dv; end
    else         begin pin_a = sv; pin_b = dv; end
  endtask

  task automatic pulse_start();
    start = 1'b1;
    step();
    start = 1'b0;
  endtask

  task automatic wait_valid(string tag);
    int n = 0;
    while (!res_valid && n < 5000) begin step(); n++; end
    chk({tag, " valid"}, int'(res_valid), 1);
  endtask

  task automatic take_result();
    res_ready = 1'b1;
    step();
    res_ready = 1'b0;
  endtask

  task automatic run_vec(int i);
    pin_sel  = V_SEL[i][0];
    tick_div = PSC_W'(V_PSC[i]);
    cnt_mod  = CNT_W'(V_MOD[i]);
    edge_div = 2'(V_K[i]);
    s_p = V_P[i]; s_h = 0; s_ph = 0;
    repeat (12) step();
    s_h = V_H[i]; s_ph = 0;
    repeat (V_OFF[i]) step();
    pulse_start();
    wait_valid(vtag(i));
    chk({vtag(i), " period"}, int'(res_period), V_EP[i]);
    chk({vtag(i), " high"}, int'(res_high), V_EH[i]);
  endtask

  initial begin
    repeat (4) step();
    chk("R1 valid at reset", int'(res_valid), 0);
    chk("R1 timeout at reset", int'(timed_out), 0);
    rst_n = 1'b1;
    repeat (3) step();

    for (int i = 0; i < NV; i++) begin
      run_vec(i);
      if (i == 0) begin
        // R2 and R10: start during a pending result changes nothing
        repeat (3) step();
        pulse_start();
        repeat (3) step();
        chk("R10 held valid", int'(res_valid), 1);
        chk("R2 period kept", int'(res_period), V_EP[0]);
        chk("R2 high kept", int'(res_high), V_EH[0]);
      end
      take_result();
      chk("R10 released", int'(res_valid), 0);
    end

    // R11: no edges on the selected pin
    pin_sel = 1'b0; tick_div = '0; cnt_mod = 16'd1000; edge_div = '0;
    tmo_limit = 20'd300;
    s_h = 0;
    repeat (10) step();
    pulse_start();
    repeat (290) step();
    chk("R11 not yet expired", int'(timed_out), 0);
    repeat (20) step();
    chk("R11 expired", int'(timed_out), 1);
    chk("R11 no result", int'(res_valid), 0);

    // R11: next start clears the flag and measures normally
    tmo_limit = 20'd5000;
    s_p = 40; s_h = 10; s_ph = 0;
    repeat (20) step();
    pulse_start();
    step();
    chk("R11 cleared on start", int'(timed_out), 0);
    wait_valid("R11 recovery");
    chk("R11 recovery period", int'(res_period), 40);
    chk("R11 recovery high", int'(res_high), 10);
    take_result();

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule